// File: doc/BRIEF.md
# Transmit Status Word Queue

This block turns every transmit completion into a 32-bit status word and holds the words in order until the host collects them. The transmit MAC signals a completion with a one-cycle strobe. With it come the 16-bit tag that the host attached to the packet's transmit command and twelve per-packet condition flags. The block packs these into a word with a fixed layout. The upper half holds the tag, bit 15 is a summary error bit, bits 14:12 are zero, and bits 11:0 hold the raw flags. Bit 11 is the loss-of-carrier indication.

The host sees the oldest word on a show-ahead read port and pops it with a read strobe. A used-count output tells the host how many words are waiting.

When the queue is full, the block normally lowers its transmit-enable output so that the MAC stops sending. A completion that still arrives in that state is lost and is flagged on a one-cycle error output. When the discard mode input is high, transmit-enable stays high. Completions that find the queue full are then dropped without any error, and the host must work out for itself that status went missing.

Top module: `tx_status_fifo`

## Requirements
- R1: A completion strobe (`done_valid` high for one cycle) that finds the queue not full stores exactly one word. `used_cnt` rises by one on the next clock edge unless a pop happens in the same cycle, in which case it stays the same.
- R2: In each stored word, bits 31:16 equal the tag given with the completion and bits 11:0 equal `done_flags[11:0]` bit for bit. Bit 11 is the loss-of-carrier flag.
- R3: Bit 15 of each stored word equals the OR of word bits 11, 10, 9, 8, 2 and 1. Flags 7..3 and 0 do not affect it.
- R4: Bits 14:12 of every stored word are zero.
- R5: When `discard_mode` is 0, `tx_en` is 0 exactly while `used_cnt` equals DEPTH and 1 otherwise. When `discard_mode` is 1, `tx_en` is 1 at all times.
- R6: A completion that arrives while `used_cnt` equals DEPTH is dropped, even if a host read happens in the same cycle. The stored words and their order are left unchanged.
- R7: When `discard_mode` is 0, a dropped completion drives `tx_err` high for exactly the one cycle after its strobe. When `discard_mode` is 1, `tx_err` stays 0.
- R8: After the queue has been full, one host read is enough for the next completion to be stored again.
- R9: Words leave in arrival order. `rd_data` shows the oldest stored word, and `used_cnt` always equals the number of stored words.
- R10: A host read while the queue is empty leaves `used_cnt` at 0. While the queue is empty, `rd_data` reads 0.
- R11: After reset, `used_cnt` is 0, `rd_data` is 0, `tx_err` is 0 and `tx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid | input | 1 | One-cycle strobe marking a finished packet |
| done_tag | input | 16 | Host tag of the finished packet |
| done_flags | input | 12 | Per-packet condition flags; bit 11 is loss of carrier |
| discard_mode | input | 1 | 1: keep transmitting when full and drop new status silently |
| host_rd | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest stored word, or 0 when the queue is empty |
| used_cnt | output | $clog2(DEPTH+1) | Number of stored words |
| tx_en | output | 1 | Transmit permission to the MAC |
| tx_err | output | 1 | One-cycle pulse for a status word lost in normal mode |

## Verification
The bench fills the queue to exactly DEPTH and then pushes into it. It does this alone, and also together with a host read in the same cycle. A design that accepted either push would lose the oldest word or let `used_cnt` pass DEPTH, and one that flagged the wrong cycle or the wrong mode would show a misplaced or spurious `tx_err`. Flag patterns are chosen so that only the summary bits are set, or only the excluded bits are set. A design with a wrong summary mask would show a wrong bit 15. Reads into an empty queue and a read followed by a push after a full state are also covered. A design that moved a pointer on an empty read, or stayed locked after an overrun, would produce the wrong word or the wrong count.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int TAG_W  = 16;
    localparam int FLAG_W = 12;

    // flag positions that feed the summary error bit
    localparam logic [FLAG_W-1:0] SUM_MASK = 12'b1111_0000_0110;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              err_sum;
        logic [2:0]        zero_pad;
        logic [FLAG_W-1:0] flags;
    } txs_word_t;

endpackage

// File: rtl/txs_word_build.sv
module txs_word_build
    import txs_pkg::*;
(
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [FLAG_W-1:0] flags_i,
    output txs_word_t         word_o
);

    always_comb begin
        word_o          = '0;
        word_o.tag      = tag_i;
        word_o.flags    = flags_i;
        word_o.err_sum  = |(flags_i & SUM_MASK);
        word_o.zero_pad = 3'b000;
    end

endmodule

// File: rtl/txs_fifo_store.sv
module txs_fifo_store
    import txs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  txs_word_t     word_i,
    output txs_word_t     head_o,
    output logic [CW-1:0] count_o
);

    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    txs_word_t  mem_q [DEPTH];

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wptr = wrap_inc(st_q.wptr);
        if (pop_i)  st_d.rptr = wrap_inc(st_q.rptr);
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[st_q.wptr] <= word_i;
    end

    assign head_o  = mem_q[st_q.rptr];
    assign count_o = st_q.cnt;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !push_i) |=> st_q.cnt == '0);

endmodule

// File: rtl/tx_status_fifo.sv
module tx_status_fifo
    import txs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic [FLAG_W-1:0] done_flags,
    input  logic              discard_mode,
    input  logic              host_rd,
    output logic [31:0]       rd_data,
    output logic [CW-1:0]     used_cnt,
    output logic              tx_en,
    output logic              tx_err
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic err;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    txs_word_t  new_word, head_word;
    logic [CW-1:0] cnt;
    logic is_full, is_empty, do_push, do_pop;

    txs_word_build u_build (
        .tag_i   (done_tag),
        .flags_i (done_flags),
        .word_o  (new_word)
    );

    txs_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (do_push),
        .pop_i   (do_pop),
        .word_i  (new_word),
        .head_o  (head_word),
        .count_o (cnt)
    );

    always_comb begin
        is_full  = (cnt == FULL_CNT);
        is_empty = (cnt == '0);
        do_push  = done_valid && !is_full;
        do_pop   = host_rd && !is_empty;
        ctl_d.err = done_valid && is_full && !discard_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_data  = is_empty ? 32'd0 : head_word;
    assign used_cnt = cnt;
    assign tx_en    = discard_mode || !is_full;
    assign tx_err   = ctl_q.err;

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && used_cnt != FULL_CNT && !host_rd) |=> used_cnt == $past(used_cnt) + 1'b1);

    assert_summary_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (used_cnt != '0) |-> rd_data[15] == (|{rd_data[11:8], rd_data[2:1]}));

    assert_zero_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14:12] == 3'b000);

    assert_hold_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!discard_mode && used_cnt == FULL_CNT) |-> !tx_en);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && used_cnt == FULL_CNT && !discard_mode) |=> tx_err);

    assert_quiet_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        discard_mode |=> !tx_err);

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (used_cnt == '0) |-> rd_data == 32'd0);

endmodule

// File: tb/tb_tx_status_fifo.sv
module tb_tx_status_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic done_valid = 0;
    logic [15:0] done_tag = '0;
    logic [11:0] done_flags = '0;
    logic discard_mode = 0;
    logic host_rd = 0;
    logic [31:0] rd_data;
    logic [CW-1:0] used_cnt;
    logic tx_en, tx_err;

    int total = 0;
    int bad = 0;
    logic [31:0] mq[$];
    bit exp_err = 0;

    tx_status_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .done_tag(done_tag),
        .done_flags(done_flags), .discard_mode(discard_mode), .host_rd(host_rd),
        .rd_data(rd_data), .used_cnt(used_cnt), .tx_en(tx_en), .tx_err(tx_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mkword(input logic [15:0] tg, input logic [11:0] fl);
        return {tg, |{fl[11:8], fl[2:1]}, 3'b000, fl};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [31:0] eh;
        eh = (mq.size() > 0) ? mq[0] : 32'd0;
        chk(rd_data === eh, "R9 head word", rd_data, eh);
        chk(used_cnt === CW'(mq.size()), "R1 used count", 32'(used_cnt), 32'(mq.size()));
        chk(tx_en === (discard_mode || mq.size() != DEPTH), "R5 tx_en", 32'(tx_en),
            32'(discard_mode || mq.size() != DEPTH));
        chk(tx_err === exp_err, "R7 tx_err", 32'(tx_err), 32'(exp_err));
    endtask

    task automatic step(input logic v, input logic [15:0] tg, input logic [11:0] fl,
                        input logic rd, input logic md);
        bit full, en;
        done_valid = v; done_tag = tg; done_flags = fl; host_rd = rd; discard_mode = md;
        full = (mq.size() == DEPTH);
        en = v && full && !md;
        if (rd && mq.size() > 0) void'(mq.pop_front());
        if (v && !full) mq.push_back(mkword(tg, fl));
        @(posedge clk);
        exp_err = en;
        @(negedge clk);
        compare_all();
        done_valid = 0; host_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        chk(used_cnt == 0, "R11 count", 32'(used_cnt), 0);
        chk(rd_data == 0, "R11 rd_data", rd_data, 0);
        chk(tx_en == 1 && tx_err == 0, "R11 tx_en/tx_err", {tx_en, tx_err}, 32'b10);

        // R2 R3 R4 field layout
        step(1, 16'hA5C3, 12'h800, 0, 0);
        chk(rd_data == 32'hA5C3_8800, "R2 tag and loss-of-carrier", rd_data, 32'hA5C3_8800);
        step(1, 16'h1234, 12'h0F9, 0, 0);
        step(1, 16'hBEEF, 12'h106, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(rd_data == 32'h1234_00F9, "R3 excluded flags give no summary", rd_data, 32'h1234_00F9);
        step(0, 0, 0, 1, 0);
        chk(rd_data == 32'hBEEF_8106, "R3 summary set", rd_data, 32'hBEEF_8106);
        chk(rd_data[14:12] == 0, "R4 zero pad", 32'(rd_data[14:12]), 0);
        step(0, 0, 0, 1, 0);

        // R10 empty reads
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
        chk(used_cnt == 0 && rd_data == 0, "R10 empty read", 32'(used_cnt), 0);

        // fill, normal mode
        for (int i = 0; i < DEPTH; i++) step(1, 16'(16'h100 + i), 12'(i * 37), 0, 0);
        chk(tx_en == 0, "R5 hold off when full", 32'(tx_en), 0);
        snap = rd_data;
        step(1, 16'hDEAD, 12'hFFF, 0, 0);
        chk(tx_err == 1, "R7 error pulse", 32'(tx_err), 1);
        step(0, 0, 0, 0, 0);
        chk(tx_err == 0, "R7 pulse is one cycle", 32'(tx_err), 0);
        chk(rd_data == snap && used_cnt == DEPTH, "R6 dropped word", rd_data, snap);
        step(1, 16'hCAFE, 12'h001, 1, 0);
        chk(used_cnt == DEPTH - 1, "R6 drop with same-cycle read", 32'(used_cnt), DEPTH - 1);
        step(1, 16'h7777, 12'h004, 0, 0);
        chk(used_cnt == DEPTH, "R8 store after read", 32'(used_cnt), DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 0, 1, 0);
        chk(rd_data == 32'h7777_8004, "R8 stored word arrives last", rd_data, 32'h7777_8004);
        step(0, 0, 0, 1, 0);

        // discard mode
        for (int i = 0; i < DEPTH + 3; i++) step(1, 16'(16'h200 + i), 12'(i), 0, 1);
        chk(tx_en == 1 && tx_err == 0, "R7 quiet discard", {tx_en, tx_err}, 32'b10);
        chk(rd_data[31:16] == 16'h200, "R6 oldest kept in discard", 32'(rd_data[31:16]), 32'h200);
        step(0, 0, 0, 1, 1);
        step(1, 16'h3333, 12'h002, 0, 1);
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 1);

        // mixed traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr, lfsr[11:0] ^ 12'h5A5, lfsr[2] & lfsr[3],
                 (i > 300) && lfsr[7]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule